// File: doc/BRIEF.md
# Broadcast Multiply-Accumulate Array with Partial-Sum Readout

This block is the compute side of one memory channel. Several compute units sit beside the banks, each unit owning a small group of neighbouring banks. A compute command carries one 256-bit broadcast word that goes to every unit at once. The bank address selects one bank from each group by position inside the group. Each unit multiplies the broadcast word lane by lane with the read data of its selected bank and adds the product into its own accumulator.

A readout command returns the partial sum of a single unit and clears that unit's accumulator. On a readout the bank address names the unit directly rather than a bank. A global clear input zeroes every accumulator. Each 256-bit word holds 16 lanes of 16-bit two's-complement integers. Products and sums keep the low 16 bits of each lane.

Top module: `mac_bcast_array`

## Requirements
- R1: After reset every accumulator is zero, `rd_valid_o` is 0 and `rd_data_o` is zero.
- R2: `cmd_i` = 2'b01 (compute) with bank address A below the banks-per-unit count (2 by default) updates every unit u at the next clock edge, lane by lane: acc[u][l] = acc[u][l] + bcast[l] * bank[u*2+A][l], truncated to 16 bits. Lane l is bits [16l+15:16l] of a word. Bank i is bits [256i+255:256i] of `bank_rd_i`.
- R3: A compute command with A=0 takes weights only from the even banks (0,2,4,…) for units 0,1,2,…. With A=1 it takes them only from the odd banks (1,3,5,…).
- R4: A compute command with A at or above the banks-per-unit count leaves every accumulator unchanged.
- R5: `cmd_i` = 2'b10 (readout) with A below the unit count (8) raises `rd_valid_o` and drives unit A's accumulator on `rd_data_o` in the cycle after the command. Unit A's accumulator is zero afterwards.
- R6: A readout with A at or above the unit count raises `rd_valid_o` with `rd_data_o` zero and clears no accumulator.
- R7: In any cycle that does not follow a readout command, `rd_valid_o` is 0 and `rd_data_o` is zero.
- R8: `clr_all_i` zeroes every accumulator at the next edge and overrides a compute in the same cycle. A readout in the same cycle still returns the value held before the clear.
- R9: With `cmd_i` at 2'b00 or 2'b11 and no clear, every accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr_all_i | input | 1 | Zero all accumulators |
| cmd_i | input | 2 | 00 idle, 01 compute, 10 readout, 11 idle |
| bank_addr_i | input | 4 | Bank position (compute) or unit index (readout) |
| bcast_i | input | 256 | Broadcast operand word |
| bank_rd_i | input | 4096 | Read data of all 16 banks, bank i at bits [256i+255:256i] |
| rd_data_o | output | 256 | Partial sum returned by a readout |
| rd_valid_o | output | 1 | Readout data strobe |

## Verification
Two operations can fall in the same cycle: the global clear with a compute, and the global clear with a readout. The bench first builds non-zero sums. It then raises `clr_all_i` together with a compute command and reads every unit back, expecting zero in every unit. It also raises `clr_all_i` together with a readout, expecting the pre-clear sum of the addressed unit on the output and zero in all units afterwards. A readout that directly follows a compute is another meeting point of two functions; the bench judges it by expecting the freshly accumulated value.

// File: rtl/mac_bcast_pkg.sv
package mac_bcast_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_MAC  = 2'b01,
    CMD_READ = 2'b10,
    CMD_RSVD = 2'b11
  } cmd_e;
endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mac_wgt_router.sv
module mac_wgt_router #(
  parameter int NUM_BANKS = 16,
  parameter int NUM_UNITS = 8,
  parameter int DATA_W    = 256,
  parameter int ADDR_W    = 4
) (
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rd_i,
  input  logic [ADDR_W-1:0]           sel_i,
  output logic [NUM_UNITS*DATA_W-1:0] wgt_o,
  output logic                        sel_ok_o
);
  localparam int BPU = NUM_BANKS / NUM_UNITS;

  always_comb begin
    sel_ok_o = 1'b0;
    for (int b = 0; b < BPU; b++) begin
      if (sel_i == ADDR_W'(b)) sel_ok_o = 1'b1;
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    always_comb begin
      wgt_o[u*DATA_W +: DATA_W] = '0;
      for (int b = 0; b < BPU; b++) begin
        if (sel_i == ADDR_W'(b))
          wgt_o[u*DATA_W +: DATA_W] = bank_rd_i[(u*BPU+b)*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int DATA_W = 256,
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mac_en_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] bcast_i,
  input  logic [DATA_W-1:0] wgt_i,
  output logic [DATA_W-1:0] acc_o
);
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] acc_q, acc_d, sum_w;
  logic              acc_en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] prod;
    assign prod = bcast_i[l*LANE_W +: LANE_W] * wgt_i[l*LANE_W +: LANE_W];
    assign sum_w[l*LANE_W +: LANE_W] = acc_q[l*LANE_W +: LANE_W] + prod;
  end

  assign acc_en = clr_i | mac_en_i;

  always_comb begin
    acc_d = acc_q;
    if (clr_i)         acc_d = '0;
    else if (mac_en_i) acc_d = sum_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mac_rdout.sv
module mac_rdout #(
  parameter int NUM_UNITS = 8,
  parameter int DATA_W    = 256,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req_i,
  input  logic [ADDR_W-1:0]           unit_i,
  input  logic [NUM_UNITS*DATA_W-1:0] acc_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic                        rd_valid_o
);
  logic [DATA_W-1:0] data_d, data_q;
  logic              valid_q, data_en;

  always_comb begin
    data_d = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (rd_req_i && unit_i == ADDR_W'(u)) data_d = acc_i[u*DATA_W +: DATA_W];
    end
  end

  assign data_en = rd_req_i | valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_req_i;
      if (data_en) data_q <= data_d;
    end
  end

  assign rd_data_o  = data_q;
  assign rd_valid_o = valid_q;
endmodule

// File: rtl/mac_bcast_array.sv
module mac_bcast_array #(
  parameter int NUM_BANKS = 16,
  parameter int NUM_UNITS = 8,
  parameter int DATA_W    = 256,
  parameter int LANE_W    = 16,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_all_i,
  input  logic [1:0]                  cmd_i,
  input  logic [ADDR_W-1:0]           bank_addr_i,
  input  logic [DATA_W-1:0]           bcast_i,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rd_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic                        rd_valid_o
);
  import mac_bcast_pkg::*;

  cmd_e                        cmd;
  logic                        rst_sync_n;
  logic                        is_mac, is_read, sel_ok, mac_en;
  logic [NUM_UNITS*DATA_W-1:0] wgt_flat, acc_flat;
  logic [NUM_UNITS-1:0]        unit_clr;

  assign cmd     = cmd_e'(cmd_i);
  assign is_mac  = (cmd == CMD_MAC);
  assign is_read = (cmd == CMD_READ);
  assign mac_en  = is_mac & sel_ok;

  mac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mac_wgt_router #(
    .NUM_BANKS (NUM_BANKS),
    .NUM_UNITS (NUM_UNITS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
  ) u_router (
    .bank_rd_i (bank_rd_i),
    .sel_i     (bank_addr_i),
    .wgt_o     (wgt_flat),
    .sel_ok_o  (sel_ok)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign unit_clr[u] = clr_all_i | (is_read && bank_addr_i == ADDR_W'(u));

    mac_unit #(
      .DATA_W (DATA_W),
      .LANE_W (LANE_W)
    ) u_mac (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .mac_en_i (mac_en),
      .clr_i    (unit_clr[u]),
      .bcast_i  (bcast_i),
      .wgt_i    (wgt_flat[u*DATA_W +: DATA_W]),
      .acc_o    (acc_flat[u*DATA_W +: DATA_W])
    );
  end

  mac_rdout #(
    .NUM_UNITS (NUM_UNITS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
  ) u_rdout (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_req_i   (is_read),
    .unit_i     (bank_addr_i),
    .acc_i      (acc_flat),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );
endmodule

// File: rtl/mac_bcast_chk.sv
module mac_bcast_chk #(
  parameter int NUM_BANKS = 16,
  parameter int NUM_UNITS = 8,
  parameter int DATA_W    = 256,
  parameter int ADDR_W    = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        clr_all_i,
  input logic [1:0]                  cmd_i,
  input logic [ADDR_W-1:0]           bank_addr_i,
  input logic [NUM_UNITS*DATA_W-1:0] acc_flat,
  input logic [DATA_W-1:0]           rd_data_o,
  input logic                        rd_valid_o
);
  localparam int BPU = NUM_BANKS / NUM_UNITS;

  logic addr_unit_ok, addr_bank_ok;
  assign addr_unit_ok = ({1'b0, bank_addr_i} < (ADDR_W+1)'(NUM_UNITS));
  assign addr_bank_ok = ({1'b0, bank_addr_i} < (ADDR_W+1)'(BPU));

  assert_read_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == 2'b10 |=> rd_valid_o);

  assert_quiet_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i != 2'b10 |=> (!rd_valid_o && rd_data_o == '0));

  assert_oor_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'b10 && !addr_unit_ok) |=> rd_data_o == '0);

  assert_oor_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'b10 && !addr_unit_ok && !clr_all_i) |=> $stable(acc_flat));

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> acc_flat == '0);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i[0] == cmd_i[1] && !clr_all_i) |=> $stable(acc_flat));

  assert_bad_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'b01 && !addr_bank_ok && !clr_all_i) |=> $stable(acc_flat));

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_clr
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 2'b10 && bank_addr_i == ADDR_W'(u)) |=> acc_flat[u*DATA_W +: DATA_W] == '0);
  end
endmodule

bind mac_bcast_array mac_bcast_chk #(
  .NUM_BANKS (NUM_BANKS),
  .NUM_UNITS (NUM_UNITS),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .clr_all_i   (clr_all_i),
  .cmd_i       (cmd_i),
  .bank_addr_i (bank_addr_i),
  .acc_flat    (acc_flat),
  .rd_data_o   (rd_data_o),
  .rd_valid_o  (rd_valid_o)
);

// File: tb/mac_bcast_array_bench.sv
module mac_bcast_array_bench;
  localparam int NB = 16;
  localparam int NU = 8;
  localparam int DW = 256;
  localparam int NL = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           clr_all = 1'b0;
  logic [1:0]     cmd = 2'b00;
  logic [3:0]     ba = 4'd0;
  logic [DW-1:0]  bcast = '0;
  logic [NB*DW-1:0] bank_rd = '0;
  logic [DW-1:0]  rd_data;
  logic           rd_valid;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] mdl [NU][NL];

  always #2.5 clk = ~clk;

  mac_bcast_array u_mac_bcast_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_all_i   (clr_all),
    .cmd_i       (cmd),
    .bank_addr_i (ba),
    .bcast_i     (bcast),
    .bank_rd_i   (bank_rd),
    .rd_data_o   (rd_data),
    .rd_valid_o  (rd_valid)
  );

  function automatic logic [15:0] pat(int p, int b, int l);
    if (p == 0) return (b < 0) ? 16'h8000 : ((l % 2 == 0) ? 16'hFFFF : 16'h7FFF);
    if (p == 1) return (b < 0) ? 16'h7FFF : 16'h7FFF;
    return 16'(p * 7919 + (b + 1) * 257 + l * 31 + p * (b + 2) * l * 13);
  endfunction

  function automatic logic [DW-1:0] mword(int u);
    logic [DW-1:0] w;
    for (int l = 0; l < NL; l++) w[l*16 +: 16] = mdl[u][l];
    return w;
  endfunction

  task automatic load(int p);
    for (int l = 0; l < NL; l++) bcast[l*16 +: 16] = pat(p, -1, l);
    for (int b = 0; b < NB; b++)
      for (int l = 0; l < NL; l++) bank_rd[b*DW + l*16 +: 16] = pat(p, b, l);
  endtask

  task automatic model_mac(int a);
    logic [15:0] pr;
    if (a < 2)
      for (int u = 0; u < NU; u++)
        for (int l = 0; l < NL; l++) begin
          pr = bcast[l*16 +: 16] * bank_rd[(u*2+a)*DW + l*16 +: 16];
          mdl[u][l] = mdl[u][l] + pr;
        end
  endtask

  task automatic model_zero();
    for (int u = 0; u < NU; u++)
      for (int l = 0; l < NL; l++) mdl[u][l] = 16'h0;
  endtask

  task automatic step(logic [1:0] c, int a, logic clr);
    cmd = c; ba = 4'(a); clr_all = clr;
    @(posedge clk);
    @(negedge clk);
    cmd = 2'b00; clr_all = 1'b0;
  endtask

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_mac(int a, int p);
    load(p);
    model_mac(a);
    step(2'b01, a, 1'b0);
  endtask

  task automatic do_read(int a, string req);
    logic [DW-1:0] exp;
    exp = (a < NU) ? mword(a) : '0;
    step(2'b10, a, 1'b0);
    chk({req, " valid"}, DW'(rd_valid), DW'(1));
    chk({req, " data"}, rd_data, exp);
    if (a < NU)
      for (int l = 0; l < NL; l++) mdl[a][l] = 16'h0;
  endtask

  task automatic read_all(string req);
    for (int u = 0; u < NU; u++) do_read(u, req);
  endtask

  initial begin
    model_zero();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset valid", DW'(rd_valid), '0);
    chk("R1 reset data", rd_data, '0);
    read_all("R1 reset accumulators");

    for (int p = 0; p < 12; p++) begin
      do_mac(p % 2, p);
      if (p % 4 == 3) begin
        read_all("R2 R3 R5 readout");
        do_read(0, "R5 cleared after readout");
      end
    end

    do_mac(0, 5);
    do_read(4, "R2 back-to-back compute then readout");
    read_all("R3 even-bank only");
    do_mac(1, 6);
    read_all("R3 odd-bank only");

    do_mac(0, 20);
    do_mac(2, 21);
    do_mac(3, 22);
    do_mac(15, 23);
    read_all("R4 out-of-range bank position");

    do_mac(1, 30);
    for (int a = NU; a < 16; a++) do_read(a, "R6 out-of-range readout");
    read_all("R6 no accumulator cleared");

    do_mac(0, 31);
    step(2'b00, 0, 1'b0);
    chk("R7 idle valid", DW'(rd_valid), '0);
    chk("R7 idle data", rd_data, '0);
    repeat (4) step(2'b00, 0, 1'b0);
    step(2'b11, 1, 1'b0);
    chk("R7 reserved cmd valid", DW'(rd_valid), '0);
    read_all("R9 hold while idle");

    do_mac(0, 40);
    load(41);
    step(2'b01, 1, 1'b1);
    model_zero();
    read_all("R8 clear beats compute");

    do_mac(1, 42);
    begin
      logic [DW-1:0] exp;
      exp = mword(2);
      step(2'b10, 2, 1'b1);
      chk("R8 readout with clear valid", DW'(rd_valid), DW'(1));
      chk("R8 readout with clear data", rd_data, exp);
      model_zero();
    end
    read_all("R8 all cleared");

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule